// File: doc/BRIEF.md
# Repeated String Operation Engine

This block executes one string primitive of a 16-bit segmented processor: copy, compare, scan, load or store. Each runs at byte or word size, alone or under a repeat prefix. A pulse on `start` captures the operation, the size, the prefix, the direction flag, the two segment values and working copies of the source index, destination index, count, accumulator and status flags. The engine then runs every element through one memory port and raises `done` when the last element is finished. The updated registers are valid on the outputs at that moment.

The memory side is a request channel and a response channel, each with valid/ready. A request stays valid, and its address, write enable, size and write data stay unchanged, until the cycle in which `mem_req_ready` is high. Only a read produces a response. The engine raises `mem_rsp_ready` only while it waits for read data, and it issues no new request until that data has arrived. The memory can therefore stall either channel for any number of cycles. Pins for control and results have no handshake.

Top module: `strop_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req_valid` are low.
- R2: Each request address is segment × 16 + offset, taken modulo 2^20. Source elements use `ds` with the source index, and destination elements use `es` with the destination index. A word access covers the addressed byte (low half) and the next byte (high half). Byte data travels in bits 7:0, and a byte write sends zero in bits 15:8.
- R3: Copy (`op`=0) reads the element at the source address and writes it to the destination address.
- R4: Compare (`op`=1) reads the source element and then the destination element and forms source minus destination. It writes nothing. It sets `flags_out` = {overflow, sign, zero, aux carry, even parity of the low result byte, borrow} in bits 5:0, computed at the element width.
- R5: Scan (`op`=2) subtracts the destination element from the accumulator and sets flags as in R4. A byte scan uses only bits 7:0 of the accumulator.
- R6: Load (`op`=3) reads the source element into the accumulator, and a byte load keeps accumulator bits 15:8. Store (`op`=4) writes the accumulator to the destination address.
- R7: After each element, every index the operation used moves by 1 (byte) or 2 (word). It moves up when `df`=0 and down when `df`=1. An index the operation did not use is unchanged.
- R8: With `rep`=0 (no prefix), exactly one element is processed and the count is returned unchanged.
- R9: With `rep` of 1, 2 or 3, the count drops by one per element and the run ends when it reaches zero. A starting count of zero processes no element and makes no memory request, and all registers and flags return unchanged.
- R10: `rep`=2 (repeat while equal) also ends compare and scan after an element that clears the zero flag. `rep`=3 (repeat while not equal) also ends them after an element that sets it. For copy, load and store, both behave exactly like `rep`=1.
- R11: `done` is high for exactly one cycle per run, and the final values are on the outputs in that cycle. A `start` while `busy` is high is ignored.
- R12: A pending request holds its fields stable until it is accepted. The engine reads a response only in a cycle in which it has `mem_rsp_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the inputs and begin a run (used only when idle) |
| op | input | 3 | 0 copy, 1 compare, 2 scan, 3 load, 4 store |
| word | input | 1 | 1 selects word elements, 0 selects byte elements |
| rep | input | 2 | 0 none, 1 repeat, 2 repeat while equal, 3 repeat while not equal |
| df | input | 1 | Direction: 0 up, 1 down |
| ds | input | 16 | Source segment |
| es | input | 16 | Destination segment |
| si_in | input | 16 | Starting source index |
| di_in | input | 16 | Starting destination index |
| cx_in | input | 16 | Starting count |
| acc_in | input | 16 | Starting accumulator |
| flags_in | input | 6 | Starting status flags, same packing as R4 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| si_out | output | 16 | Source index |
| di_out | output | 16 | Destination index |
| cx_out | output | 16 | Count |
| acc_out | output | 16 | Accumulator |
| flags_out | output | 6 | Status flags |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_word | output | 1 | Access size is a word |
| mem_req_addr | output | 20 | Byte address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine accepts read data |
| mem_rsp_data | input | 16 | Read data |

## Verification
A wrong index or direction shows up in the next element's request address, one or two cycles after the element that caused it. It also shows up in the returned index when `done` rises. A wrong count or termination decision changes how many requests a run makes and what count it returns, and both are visible as soon as `done` pulses. A wrong flag computation either ends a conditional repeat early or late or leaves wrong `flags_out`. A stray write corrupts the memory image, which is compared byte by byte after every run.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    OP_COPY  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } str_op_e;

  typedef enum logic [1:0] {
    RP_NONE     = 2'd0,
    RP_ALL      = 2'd1,
    RP_WHILE_EQ = 2'd2,
    RP_WHILE_NE = 2'd3
  } rep_e;

  // status packing, MSB first: overflow, sign, zero, aux, parity, carry
  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic par;
    logic carry;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/strop_agu.sv
// Segment:offset to physical byte address.
module strop_agu #(
  parameter int OFFW      = 16,
  parameter int AW        = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic [OFFW-1:0] seg,
  input  logic [OFFW-1:0] off,
  output logic [AW-1:0]   phys
);
  logic [AW-1:0] seg_base;
  assign seg_base = AW'(seg) << SEG_SHIFT;
  assign phys     = seg_base + AW'(off);
endmodule

// File: rtl/strop_stepper.sv
// Next index value: +/-1 for bytes, +/-2 for words.
module strop_stepper #(
  parameter int OFFW = 16
) (
  input  logic [OFFW-1:0] off,
  input  logic            word,
  input  logic            df,
  output logic [OFFW-1:0] nxt
);
  logic [OFFW-1:0] delta;
  assign delta = word ? OFFW'(2) : OFFW'(1);
  assign nxt   = df ? (off - delta) : (off + delta);
endmodule

// File: rtl/strop_alu.sv
// Subtract-and-flag unit for compare and scan.
module strop_alu
  import strop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          word,
  output stat_t         st
);
  localparam int HW = DW / 2;

  logic [DW:0]   diff_w;
  logic [HW:0]   diff_h;
  logic [DW-1:0] res;
  logic          brw, ma, mb, mr;

  assign diff_w = {1'b0, a} - {1'b0, b};
  assign diff_h = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]};

  always_comb begin
    if (word) begin
      res = diff_w[DW-1:0];
      brw = diff_w[DW];
      ma  = a[DW-1];
      mb  = b[DW-1];
      mr  = diff_w[DW-1];
    end else begin
      res = {{HW{1'b0}}, diff_h[HW-1:0]};
      brw = diff_h[HW];
      ma  = a[HW-1];
      mb  = b[HW-1];
      mr  = diff_h[HW-1];
    end
    st.carry = brw;
    st.zero  = (res == '0);
    st.sign  = mr;
    st.ovf   = (ma ^ mb) & (ma ^ mr);
    st.aux   = a[4] ^ b[4] ^ res[4];
    st.par   = ~^res[7:0];
  end
endmodule

// File: rtl/strop_term.sv
// Decides whether another element follows the current one.
module strop_term
  import strop_pkg::*;
(
  input  str_op_e op,
  input  rep_e    rep,
  input  logic    cnt_zero_after,
  input  logic    zf,
  output logic    more
);
  logic is_cmp;
  assign is_cmp = (op == OP_CMP) || (op == OP_SCAN);

  always_comb begin
    more = 1'b0;
    if (rep != RP_NONE && !cnt_zero_after) begin
      if (!is_cmp)                  more = 1'b1;
      else if (rep == RP_WHILE_EQ)  more = zf;
      else if (rep == RP_WHILE_NE)  more = !zf;
      else                          more = 1'b1;
    end
  end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int DW        = 16,
  parameter int OFFW      = 16,
  parameter int AW        = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              word,
  input  logic [1:0]        rep,
  input  logic              df,
  input  logic [OFFW-1:0]   ds,
  input  logic [OFFW-1:0]   es,
  input  logic [OFFW-1:0]   si_in,
  input  logic [OFFW-1:0]   di_in,
  input  logic [OFFW-1:0]   cx_in,
  input  logic [DW-1:0]     acc_in,
  input  logic [STAT_W-1:0] flags_in,
  output logic              busy,
  output logic              done,
  output logic [OFFW-1:0]   si_out,
  output logic [OFFW-1:0]   di_out,
  output logic [OFFW-1:0]   cx_out,
  output logic [DW-1:0]     acc_out,
  output logic [STAT_W-1:0] flags_out,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic              mem_req_word,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DW-1:0]     mem_rsp_data
);
  localparam int HW = DW / 2;

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_SRC, S_SRC_W, S_DST, S_DST_W, S_WR, S_STEP, S_DONE
  } state_e;

  state_e          state;
  str_op_e         op_q;
  rep_e            rep_q;
  logic            word_q, df_q;
  logic [OFFW-1:0] ds_q, es_q, si_q, di_q, cx_q;
  logic [DW-1:0]   acc_q, tmp_q;
  stat_t           st_q;

  // ---------------- datapath helpers ----------------
  logic [AW-1:0]   src_addr, dst_addr;
  logic [OFFW-1:0] si_nxt, di_nxt, cx_after;
  logic [DW-1:0]   rd_data, alu_a;
  stat_t           alu_st;
  logic            more, uses_src, uses_dst;

  strop_agu #(.OFFW(OFFW), .AW(AW), .SEG_SHIFT(SEG_SHIFT)) u_agu_src (
    .seg(ds_q), .off(si_q), .phys(src_addr));
  strop_agu #(.OFFW(OFFW), .AW(AW), .SEG_SHIFT(SEG_SHIFT)) u_agu_dst (
    .seg(es_q), .off(di_q), .phys(dst_addr));

  strop_stepper #(.OFFW(OFFW)) u_step_si (.off(si_q), .word(word_q), .df(df_q), .nxt(si_nxt));
  strop_stepper #(.OFFW(OFFW)) u_step_di (.off(di_q), .word(word_q), .df(df_q), .nxt(di_nxt));

  assign rd_data = word_q ? mem_rsp_data : {{HW{1'b0}}, mem_rsp_data[HW-1:0]};
  assign alu_a   = (op_q == OP_SCAN) ? acc_q : tmp_q;

  strop_alu #(.DW(DW)) u_alu (.a(alu_a), .b(rd_data), .word(word_q), .st(alu_st));

  assign cx_after = (rep_q != RP_NONE) ? (cx_q - OFFW'(1)) : cx_q;

  strop_term u_term (
    .op(op_q), .rep(rep_q), .cnt_zero_after(cx_after == '0),
    .zf(st_q.zero), .more(more));

  assign uses_src = (op_q == OP_COPY) || (op_q == OP_CMP) || (op_q == OP_LOAD);
  assign uses_dst = (op_q != OP_LOAD);

  // ---------------- memory port ----------------
  assign mem_req_valid = (state == S_SRC) || (state == S_DST) || (state == S_WR);
  assign mem_req_we    = (state == S_WR);
  assign mem_req_word  = word_q;
  assign mem_req_addr  = (state == S_SRC) ? src_addr : dst_addr;
  always_comb begin
    if (op_q == OP_COPY)  mem_req_wdata = tmp_q;
    else if (word_q)      mem_req_wdata = acc_q;
    else                  mem_req_wdata = {{HW{1'b0}}, acc_q[HW-1:0]};
  end
  assign mem_rsp_ready = (state == S_SRC_W) || (state == S_DST_W);

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_COPY;
      rep_q  <= RP_NONE;
      word_q <= 1'b0;
      df_q   <= 1'b0;
      ds_q   <= '0;
      es_q   <= '0;
      si_q   <= '0;
      di_q   <= '0;
      cx_q   <= '0;
      acc_q  <= '0;
      tmp_q  <= '0;
      st_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          op_q   <= str_op_e'(op);
          rep_q  <= rep_e'(rep);
          word_q <= word;
          df_q   <= df;
          ds_q   <= ds;
          es_q   <= es;
          si_q   <= si_in;
          di_q   <= di_in;
          cx_q   <= cx_in;
          acc_q  <= acc_in;
          st_q   <= stat_t'(flags_in);
          state  <= S_PLAN;
        end
        S_PLAN: begin
          if (rep_q != RP_NONE && cx_q == '0) state <= S_DONE;
          else if (op_q == OP_SCAN)            state <= S_DST;
          else if (op_q == OP_STORE)           state <= S_WR;
          else                                 state <= S_SRC;
        end
        S_SRC: if (mem_req_ready) state <= S_SRC_W;
        S_SRC_W: if (mem_rsp_valid) begin
          tmp_q <= rd_data;
          if (op_q == OP_LOAD) begin
            acc_q <= word_q ? rd_data : {acc_q[DW-1:HW], rd_data[HW-1:0]};
            state <= S_STEP;
          end else if (op_q == OP_COPY) begin
            state <= S_WR;
          end else begin
            state <= S_DST;
          end
        end
        S_DST: if (mem_req_ready) state <= S_DST_W;
        S_DST_W: if (mem_rsp_valid) begin
          st_q  <= alu_st;
          state <= S_STEP;
        end
        S_WR: if (mem_req_ready) state <= S_STEP;
        S_STEP: begin
          if (uses_src) si_q <= si_nxt;
          if (uses_dst) di_q <= di_nxt;
          cx_q  <= cx_after;
          state <= more ? S_PLAN : S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE) && (state != S_DONE);
  assign done      = (state == S_DONE);
  assign si_out    = si_q;
  assign di_out    = di_q;
  assign cx_out    = cx_q;
  assign acc_out   = acc_q;
  assign flags_out = st_q;

  // ---------------- assertions ----------------
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata) && $stable(mem_req_word));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !mem_rsp_ready);

  a_r4_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (op_q == OP_CMP || op_q == OP_SCAN || op_q == OP_LOAD) |-> !mem_req_we);

  a_r8_cx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rep_q == RP_NONE |=> cx_q == $past(cx_q));

  a_r9_one_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_STEP && rep_q != RP_NONE |=> cx_q == $past(cx_q) - OFFW'(1));

endmodule

// File: tb/strop_engine_tb.sv
module strop_engine_tb;
  import strop_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n = 1'b0, start = 1'b0, word = 1'b0, df = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  rep = '0;
  logic [15:0] ds = '0, es = '0, si_in = '0, di_in = '0, cx_in = '0, acc_in = '0;
  logic [5:0]  flags_in = '0;
  logic        busy, done;
  logic [15:0] si_out, di_out, cx_out, acc_out;
  logic [5:0]  flags_out;
  logic        mem_req_valid, mem_req_we, mem_req_word, mem_rsp_ready;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [19:0] mem_req_addr;
  logic [15:0] mem_req_wdata, mem_rsp_data = '0;

  strop_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word), .rep(rep), .df(df),
    .ds(ds), .es(es), .si_in(si_in), .di_in(di_in), .cx_in(cx_in), .acc_in(acc_in),
    .flags_in(flags_in), .busy(busy), .done(done), .si_out(si_out), .di_out(di_out),
    .cx_out(cx_out), .acc_out(acc_out), .flags_out(flags_out),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_word(mem_req_word), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data));

  int checks = 0, fails = 0, acc_cnt = 0, done_cnt = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0]  mem     [0:4095];
  logic [7:0]  ref_mem [0:4095];
  logic [7:0]  lfsr = 8'hA5;
  logic [11:0] widx, widx1;

  always @(posedge clk) begin
    lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[2];
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      acc_cnt <= acc_cnt + 1;
      widx  = mem_req_addr[11:0];
      widx1 = widx + 12'd1;
      if (mem_req_we) begin
        mem[widx] <= mem_req_wdata[7:0];
        if (mem_req_word) mem[widx1] <= mem_req_wdata[15:8];
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_req_word ? {mem[widx1], mem[widx]} : {8'h00, mem[widx]};
      end
    end
  end

  // ---------------- reference model ----------------
  function automatic logic [11:0] pidx(input logic [15:0] seg, input logic [15:0] off);
    logic [19:0] p;
    p = ({4'h0, seg} << 4) + {4'h0, off};
    return p[11:0];
  endfunction

  function automatic logic [15:0] rd_ref(input logic [11:0] i, input bit w);
    logic [11:0] j;
    j = i + 12'd1;
    return w ? {ref_mem[j], ref_mem[i]} : {8'h00, ref_mem[i]};
  endfunction

  task automatic wr_ref(input logic [11:0] i, input bit w, input logic [15:0] d);
    logic [11:0] j;
    j = i + 12'd1;
    ref_mem[i] = d[7:0];
    if (w) ref_mem[j] = d[15:8];
  endtask

  function automatic logic [5:0] sub_flags(input logic [15:0] a, input logic [15:0] b, input bit w);
    int unsigned m, msb, r, ai, bi;
    logic [5:0] f;
    m   = w ? 32'hFFFF : 32'hFF;
    msb = w ? 15 : 7;
    ai  = a & m;
    bi  = b & m;
    r   = (ai - bi) & m;
    f[0] = ai < bi;                             // borrow
    f[1] = ~^r[7:0];                            // parity
    f[2] = ((ai ^ bi ^ r) >> 4) & 1;            // aux
    f[3] = r == 0;                              // zero
    f[4] = (r >> msb) & 1;                      // sign
    f[5] = (((ai ^ bi) & (ai ^ r)) >> msb) & 1; // overflow
    return f;
  endfunction

  typedef struct {
    logic [15:0] si, di, cx, acc;
    logic [5:0]  fl;
    int          nacc, base;
  } exp_t;
  exp_t sb[$];

  // ---------------- monitor ----------------
  exp_t e_cur;
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (done_prev) chk("R11", "done wider than one cycle", {31'd0, done}, 32'd0);
    done_prev = done;
    if (done) begin
      if (sb.size() == 0) chk("R11", "unexpected done", 32'd1, 32'd0);
      else begin
        e_cur = sb.pop_front();
        chk("R7",  "si", {16'd0, si_out}, {16'd0, e_cur.si});
        chk("R7",  "di", {16'd0, di_out}, {16'd0, e_cur.di});
        chk("R9",  "cx", {16'd0, cx_out}, {16'd0, e_cur.cx});
        chk("R6",  "acc", {16'd0, acc_out}, {16'd0, e_cur.acc});
        chk("R4",  "flags", {26'd0, flags_out}, {26'd0, e_cur.fl});
        chk("R10", "access count", acc_cnt - e_cur.base, e_cur.nacc);
      end
      done_cnt++;
    end
  end

  // ---------------- driver ----------------
  task automatic run(input logic [2:0] o, input bit w, input logic [1:0] r, input bit d,
                     input logic [15:0] s_ds, s_es, s_si, s_di, s_cx, s_acc,
                     input logic [5:0] s_fl, input bit poke);
    exp_t e;
    logic [15:0] va, vb, stp;
    int prev, mism;
    e.si = s_si; e.di = s_di; e.cx = s_cx; e.acc = s_acc; e.fl = s_fl; e.nacc = 0;
    stp = w ? 16'd2 : 16'd1;
    if (r == 2'd0 || s_cx != 0) begin
      for (int it = 0; it < 70000; it++) begin
        case (o)
          3'd0: begin wr_ref(pidx(s_es, e.di), w, rd_ref(pidx(s_ds, e.si), w)); e.nacc += 2; end
          3'd1: begin
            va = rd_ref(pidx(s_ds, e.si), w); vb = rd_ref(pidx(s_es, e.di), w);
            e.fl = sub_flags(va, vb, w); e.nacc += 2;
          end
          3'd2: begin e.fl = sub_flags(e.acc, rd_ref(pidx(s_es, e.di), w), w); e.nacc += 1; end
          3'd3: begin
            va = rd_ref(pidx(s_ds, e.si), w);
            e.acc = w ? va : {e.acc[15:8], va[7:0]}; e.nacc += 1;
          end
          default: begin wr_ref(pidx(s_es, e.di), w, w ? e.acc : {8'h00, e.acc[7:0]}); e.nacc += 1; end
        endcase
        if (o == 3'd0 || o == 3'd1 || o == 3'd3) e.si = d ? e.si - stp : e.si + stp;
        if (o != 3'd3) e.di = d ? e.di - stp : e.di + stp;
        if (r == 2'd0) break;
        e.cx = e.cx - 16'd1;
        if (e.cx == 0) break;
        if ((o == 3'd1 || o == 3'd2) && r == 2'd2 && !e.fl[3]) break;
        if ((o == 3'd1 || o == 3'd2) && r == 2'd3 && e.fl[3]) break;
      end
    end
    e.base = acc_cnt;
    sb.push_back(e);
    prev = done_cnt;
    @(negedge clk);
    op = o; word = w; rep = r; df = d; ds = s_ds; es = s_es;
    si_in = s_si; di_in = s_di; cx_in = s_cx; acc_in = s_acc; flags_in = s_fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R11: start while busy must be ignored
      repeat (2) @(negedge clk);
      op = 3'd4; rep = 2'd0; si_in = 16'hFFFF; di_in = 16'h0000; cx_in = 16'h0001;
      acc_in = 16'hDEAD; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (done_cnt == prev + 1);
    repeat (2) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) mism++;
    chk("R3", "memory image mismatches", mism, 0);
  endtask

  task automatic put(input int i, input logic [7:0] v);
    mem[i] = v;
    ref_mem[i] = v;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < 4096; i++) put(i, 8'((i * 7 + 3) & 255));
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
    chk("R1", "done after reset", {31'd0, done}, 32'd0);
    chk("R1", "req valid after reset", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R8 R2: single byte copy, no prefix
    run(3'd0, 1'b0, 2'd0, 1'b0, 16'h0010, 16'h0040, 16'h0005, 16'h0020, 16'h0007, 16'h0000, 6'h00, 1'b0);
    // R7 R9: word copy up
    run(3'd0, 1'b1, 2'd1, 1'b0, 16'h0010, 16'h0040, 16'h0040, 16'h0080, 16'h0004, 16'h0000, 6'h00, 1'b0);
    // R7: byte copy down
    run(3'd0, 1'b0, 2'd1, 1'b1, 16'h0010, 16'h0040, 16'h0030, 16'h0090, 16'h0003, 16'h0000, 6'h00, 1'b0);
    // R10 R4: repeat-while-equal compare stops at third byte
    put(12'h300, 8'h11); put(12'h301, 8'h22); put(12'h302, 8'h33); put(12'h303, 8'h44); put(12'h304, 8'h55);
    put(12'h600, 8'h11); put(12'h601, 8'h22); put(12'h602, 8'h99); put(12'h603, 8'h44); put(12'h604, 8'h55);
    run(3'd1, 1'b0, 2'd2, 1'b0, 16'h0010, 16'h0040, 16'h0200, 16'h0200, 16'h0005, 16'h0000, 6'h00, 1'b0);
    // R5 R10: repeat-while-not-equal scan finds match at second word
    put(12'h700, 8'h34); put(12'h701, 8'h12); put(12'h702, 8'hEF); put(12'h703, 8'hBE);
    run(3'd2, 1'b1, 2'd3, 1'b0, 16'h0010, 16'h0040, 16'h0000, 16'h0300, 16'h0006, 16'hBEEF, 6'h00, 1'b0);
    // R5: byte scan ignores high accumulator byte
    put(12'h710, 8'h11);
    run(3'd2, 1'b0, 2'd0, 1'b0, 16'h0010, 16'h0040, 16'h0000, 16'h0310, 16'h0009, 16'h5A11, 6'h00, 1'b0);
    // R6: byte load keeps high accumulator byte
    run(3'd3, 1'b0, 2'd1, 1'b0, 16'h0010, 16'h0040, 16'h0050, 16'h0077, 16'h0002, 16'hC3FF, 6'h15, 1'b0);
    // R6 R7: word store down
    run(3'd4, 1'b1, 2'd1, 1'b1, 16'h0010, 16'h0040, 16'h0011, 16'h01A0, 16'h0003, 16'h1357, 6'h00, 1'b0);
    // R9: zero count, nothing happens
    run(3'd1, 1'b1, 2'd1, 1'b0, 16'h0010, 16'h0040, 16'h0123, 16'h0456, 16'h0000, 16'h2468, 6'h2A, 1'b0);
    // R10: repeat-while-equal on copy acts as plain repeat
    run(3'd0, 1'b0, 2'd2, 1'b0, 16'h0010, 16'h0040, 16'h0060, 16'h00C0, 16'h0003, 16'h0000, 6'h00, 1'b0);
    // R4: word compare with signed overflow
    put(12'h320, 8'h00); put(12'h321, 8'h80); put(12'h620, 8'h01); put(12'h621, 8'h00);
    run(3'd1, 1'b1, 2'd0, 1'b0, 16'h0010, 16'h0040, 16'h0220, 16'h0220, 16'h0001, 16'h0000, 6'h00, 1'b0);
    // R10: repeat-while-not-equal scan with no match runs to zero count
    put(12'h7A0, 8'h01); put(12'h7A1, 8'h02); put(12'h7A2, 8'h03);
    run(3'd2, 1'b0, 2'd3, 1'b0, 16'h0010, 16'h0040, 16'h0000, 16'h03A0, 16'h0003, 16'h00F0, 6'h00, 1'b0);
    // R11 R10: store with repeat-while-not-equal, extra start while busy
    run(3'd4, 1'b0, 2'd3, 1'b0, 16'h0010, 16'h0040, 16'h0000, 16'h0250, 16'h0004, 16'h00AB, 6'h08, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog actual=no-done expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule